// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block carries single register writes from a fast bus clock into a slow, always-on timekeeping domain that runs from a 32.768 kHz clock. A write to any forwarded address is captured in holding registers on the bus side. A toggle request crosses into the slow domain, and the slow domain issues a one-cycle write strobe with that address and data. A toggle acknowledge then returns to the bus domain, where the block drops its busy indication and raises a completion flag. Software or a bus master learns when to issue the next write from the ready (write-next) flag, the completion flag or an interrupt.

Two addresses never leave the bus domain. The status address is used only to clear the error flag, by writing a one to it. The interrupt-enable address updates its three enable bits at bus speed, with no handshake. Only one forwarded write can be in flight at a time. A second forwarded write issued while the first is still crossing is not queued: it is discarded, and a sticky error flag records the event. A pulse on the status-read strobe clears the completion flag.

Top module: `wsync_bridge`

## Requirements
- R1: After reset, busy, completion and error are 0, the ready flag is 1, all three interrupt enables are 0, irq is 0 and the slow-domain strobe is 0.
- R2: A bus write to any address other than the status or interrupt-enable address, issued while busy is 0, raises busy and lowers ready at the next bus clock edge. Busy then stays high until completion, and ready always equals the inverse of busy.
- R3: Each accepted write produces exactly one slow-domain strobe, lasting one slow-clock cycle, that carries the address and data of that write. The strobe appears no later than the fourth rising slow-clock edge after the write.
- R4: Busy falls and the completion flag rises in the same bus cycle, a few bus cycles after the slow-domain strobe.
- R5: A pulse on the status-read strobe while no write is in flight clears the completion flag at the next bus edge.
- R6: A forwarded write issued while busy is 1 sets the error flag at the next bus edge and is discarded. The write already in flight still completes with its own address and data.
- R7: The error flag stays set until a bus write to the status address has data bit 7 equal to 1. A status write with bit 7 equal to 0 leaves the flag unchanged. Status writes never produce a strobe and never change busy.
- R8: A write to the interrupt-enable address loads data bits 9, 8 and 7 into the enables for ready, completion and error, visible on ier_o[2], [1] and [0] at the next bus edge. It is never forwarded, does not touch busy, completion or error, and is legal while busy.
- R9: irq is high exactly when at least one flag is high together with its enable: ready with ier_o[2], completion with ier_o[1], error with ier_o[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | 32.768 kHz slow-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Bus write strobe, one bus cycle per write |
| wr_addr | input | AW | Bus write address |
| wr_data | input | DW | Bus write data |
| stat_rd | input | 1 | Status-read strobe; clears the completion flag |
| lp_wr | output | 1 | Slow-domain write strobe, one slow cycle |
| lp_addr | output | AW | Slow-domain write address |
| lp_data | output | DW | Slow-domain write data |
| stat_busy | output | 1 | Write in flight |
| stat_wnext | output | 1 | Ready for the next forwarded write |
| stat_wcomp | output | 1 | Last forwarded write has landed |
| stat_werr | output | 1 | Sticky: a write was dropped while busy |
| ier_o | output | 3 | Interrupt enables {ready, completion, error} |
| irq | output | 1 | Combined interrupt request |

## Verification
On every bus cycle, the assertions check how the error flag is set and held, the bus-speed load of the enables, the clear of the completion flag on a read, and that completion coincides with the fall of busy. In the slow domain they also check that the strobe is a single cycle wide. Only the bench scenarios can show the rest: that a dropped write never reaches the slow domain, that the carried address and data match the accepted write, that the strobe arrives within four slow edges, and how irq follows each enable combination across back-to-back writes, status clears and enable writes issued during a crossing.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
    // interrupt-enable field position inside the bus data word
    localparam int IE_LSB      = 7;
    localparam int IE_W        = 3;
    // status write: data bit that clears the error flag
    localparam int ERR_CLR_BIT = 7;

    typedef struct packed {
        logic busy;
        logic wcomp;
        logic werr;
    } wflags_t;
endpackage

// File: rtl/wsync_tog_sync.sv
module wsync_tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wsync_bus_side.sv
module wsync_bus_side
    import wsync_pkg::*;
#(
    parameter int            AW          = 8,
    parameter int            DW          = 32,
    parameter logic [AW-1:0] ADDR_STAT   = 8'h04,
    parameter logic [AW-1:0] ADDR_IER    = 8'h08,
    parameter int            SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            stat_rd,
    input  logic            ack_tgl,
    output logic            req_tgl,
    output logic [AW-1:0]   hold_addr,
    output logic [DW-1:0]   hold_data,
    output wflags_t         flags,
    output logic [IE_W-1:0] ier
);
    typedef struct packed {
        logic            busy;
        logic            wcomp;
        logic            werr;
        logic [IE_W-1:0] ier;
        logic            req;
        logic            ack_seen;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic    ack_sync, ack_evt, is_stat, is_ier;

    wsync_tog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );

    assign ack_evt = ack_sync ^ st_q.ack_seen;
    assign is_stat = (wr_addr == ADDR_STAT);
    assign is_ier  = (wr_addr == ADDR_IER);

    always_comb begin
        st_d          = st_q;
        st_d.ack_seen = ack_sync;
        // landing beats a read in the same cycle
        if (ack_evt) begin
            st_d.busy  = 1'b0;
            st_d.wcomp = 1'b1;
        end else if (stat_rd) begin
            st_d.wcomp = 1'b0;
        end
        if (wr_en) begin
            if (is_ier) begin
                st_d.ier = wr_data[IE_LSB +: IE_W];
            end else if (is_stat) begin
                if (wr_data[ERR_CLR_BIT]) st_d.werr = 1'b0;
            end else if (st_q.busy) begin
                st_d.werr = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.req  = ~st_q.req;
                st_d.addr = wr_addr;
                st_d.data = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl     = st_q.req;
    assign hold_addr   = st_q.addr;
    assign hold_data   = st_q.data;
    assign flags.busy  = st_q.busy;
    assign flags.wcomp = st_q.wcomp;
    assign flags.werr  = st_q.werr;
    assign ier         = st_q.ier;
endmodule

// File: rtl/wsync_slow_side.sv
module wsync_slow_side #(
    parameter int AW          = 8,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic          req_tgl,
    input  logic [AW-1:0] hold_addr,
    input  logic [DW-1:0] hold_data,
    output logic          lp_wr,
    output logic [AW-1:0] lp_addr,
    output logic [DW-1:0] lp_data,
    output logic          ack_tgl
);
    typedef struct packed {
        logic          req_seen;
        logic          wr;
        logic          ack;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slow_st_t;

    slow_st_t st_d, st_q;
    logic     req_sync, req_evt;

    wsync_tog_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (slow_clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_sync)
    );

    assign req_evt = req_sync ^ st_q.req_seen;

    always_comb begin
        st_d          = st_q;
        st_d.req_seen = req_sync;
        st_d.wr       = 1'b0;
        if (req_evt) begin
            // hold registers are quiet while busy is high
            st_d.wr   = 1'b1;
            st_d.addr = hold_addr;
            st_d.data = hold_data;
            st_d.ack  = ~st_q.ack;
        end
    end

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lp_wr   = st_q.wr;
    assign lp_addr = st_q.addr;
    assign lp_data = st_q.data;
    assign ack_tgl = st_q.ack;
endmodule

// File: rtl/wsync_bridge.sv
module wsync_bridge
    import wsync_pkg::*;
#(
    parameter int            AW          = 8,
    parameter int            DW          = 32,
    parameter logic [AW-1:0] ADDR_STAT   = 8'h04,
    parameter logic [AW-1:0] ADDR_IER    = 8'h08,
    parameter int            SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            slow_clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            stat_rd,
    output logic            lp_wr,
    output logic [AW-1:0]   lp_addr,
    output logic [DW-1:0]   lp_data,
    output logic            stat_busy,
    output logic            stat_wnext,
    output logic            stat_wcomp,
    output logic            stat_werr,
    output logic [IE_W-1:0] ier_o,
    output logic            irq
);
    logic          req_tgl, ack_tgl;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    wflags_t       flags;

    wsync_bus_side #(
        .AW(AW), .DW(DW), .ADDR_STAT(ADDR_STAT), .ADDR_IER(ADDR_IER),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .stat_rd   (stat_rd),
        .ack_tgl   (ack_tgl),
        .req_tgl   (req_tgl),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .flags     (flags),
        .ier       (ier_o)
    );

    wsync_slow_side #(
        .AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
    ) u_slow (
        .slow_clk  (slow_clk),
        .rst_n     (rst_n),
        .req_tgl   (req_tgl),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .lp_wr     (lp_wr),
        .lp_addr   (lp_addr),
        .lp_data   (lp_data),
        .ack_tgl   (ack_tgl)
    );

    assign stat_busy  = flags.busy;
    assign stat_wnext = ~flags.busy;
    assign stat_wcomp = flags.wcomp;
    assign stat_werr  = flags.werr;
    // enable order {ready, completion, error}
    assign irq = |(ier_o & {~flags.busy, flags.wcomp, flags.werr});
endmodule

// File: rtl/wsync_bridge_chk.sv
module wsync_bridge_chk
    import wsync_pkg::*;
#(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] ADDR_STAT = 8'h04,
    parameter logic [AW-1:0] ADDR_IER  = 8'h08
) (
    input logic            clk,
    input logic            slow_clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [IE_W-1:0] ie_bits,
    input logic            stat_rd,
    input logic            lp_wr,
    input logic            stat_busy,
    input logic            stat_wcomp,
    input logic            stat_werr,
    input logic [IE_W-1:0] ier_o
);
    logic fwd_wr, clr_wr;
    assign fwd_wr = wr_en && (wr_addr != ADDR_STAT) && (wr_addr != ADDR_IER);
    assign clr_wr = wr_en && (wr_addr == ADDR_STAT) && ie_bits[ERR_CLR_BIT - IE_LSB];

    // R2
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_busy) |-> $past(fwd_wr));

    // R3
    strobe_single_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        lp_wr |=> !lp_wr);

    // R4
    done_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_wcomp) |-> $fell(stat_busy));

    // R5
    read_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !stat_busy |=> !stat_wcomp);

    // R6
    overrun_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_wr && stat_busy |=> stat_werr);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_werr && !clr_wr |=> stat_werr);

    // R8
    ier_fast_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == ADDR_IER) |=> ier_o == $past(ie_bits));
endmodule

bind wsync_bridge wsync_bridge_chk #(
    .AW(AW), .ADDR_STAT(ADDR_STAT), .ADDR_IER(ADDR_IER)
) u_chk (
    .clk        (clk),
    .slow_clk   (slow_clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .ie_bits    (wr_data[wsync_pkg::IE_LSB +: wsync_pkg::IE_W]),
    .stat_rd    (stat_rd),
    .lp_wr      (lp_wr),
    .stat_busy  (stat_busy),
    .stat_wcomp (stat_wcomp),
    .stat_werr  (stat_werr),
    .ier_o      (ier_o)
);

// File: tb/sim_wsync_bridge.sv
`timescale 1ns/1ps
module sim_wsync_bridge;
    localparam int            AW   = 8;
    localparam int            DW   = 32;
    localparam logic [AW-1:0] STAT = 8'h04;
    localparam logic [AW-1:0] IER  = 8'h08;

    logic          clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
    logic          wr_en = 1'b0, stat_rd = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          lp_wr, stat_busy, stat_wnext, stat_wcomp, stat_werr, irq;
    logic [AW-1:0] lp_addr;
    logic [DW-1:0] lp_data;
    logic [2:0]    ier_o;

    always #4  clk = ~clk;       // 125 MHz
    always #37 slow_clk = ~slow_clk;

    wsync_bridge #(.AW(AW), .DW(DW), .ADDR_STAT(STAT), .ADDR_IER(IER)) u0 (
        .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
        .lp_wr(lp_wr), .lp_addr(lp_addr), .lp_data(lp_data),
        .stat_busy(stat_busy), .stat_wnext(stat_wnext), .stat_wcomp(stat_wcomp),
        .stat_werr(stat_werr), .ier_o(ier_o), .irq(irq)
    );

    int checks = 0, fails = 0;
    int accepted = 0, landed_cnt = 0;
    int lat = 0, slow_cnt = 0;
    bit started = 0, busy_m = 0, landed = 0, wcomp_m = 0, werr_m = 0;
    logic [2:0] ier_m = '0;
    logic [AW+DW-1:0] exp_q[$];

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // behavioural model: bus-side updates
    always @(posedge clk) begin
        if (rst_n && started) begin
            if (stat_rd) wcomp_m = 0;
            if (wr_en) begin
                if (wr_addr == IER) ier_m = wr_data[9:7];
                else if (wr_addr == STAT) begin
                    if (wr_data[7]) werr_m = 0;
                end else if (busy_m) werr_m = 1;
                else begin
                    busy_m = 1; landed = 0; slow_cnt = 0; lat = 0;
                    exp_q.push_back({wr_addr, wr_data});
                    accepted++;
                end
            end
        end
    end

    // slow-domain monitor
    always @(posedge slow_clk) begin
        #1;
        if (rst_n && started) begin
            if (busy_m && !landed) slow_cnt++;
            if (lp_wr) begin
                landed_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected strobe", {lp_addr, lp_data}, 0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check({lp_addr, lp_data} == e, "R3 addr/data", {lp_addr, lp_data}, e);
                    check(slow_cnt <= 4, "R3 latency", slow_cnt, 4);
                end
                landed = 1;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && started) begin
            if (busy_m && !stat_busy) begin
                if (!landed) check(0, "R4 busy fell before strobe", 0, 1);
                else begin
                    check(stat_wcomp == 1'b1, "R4 completion", stat_wcomp, 1);
                    busy_m = 0; landed = 0; lat = 0; wcomp_m = 1;
                end
            end else if (busy_m && landed) begin
                lat++;
                if (lat > 12) check(0, "R4 completion late", lat, 12);
            end
            check(stat_werr == werr_m, "R6 error flag", stat_werr, werr_m);
            check(ier_o == ier_m, "R8 enables", ier_o, ier_m);
            check(stat_wnext == !stat_busy, "R2 ready", stat_wnext, !stat_busy);
            if (busy_m) check(stat_busy == 1'b1, "R2 busy held", stat_busy, 1);
            else begin
                check(stat_busy == 1'b0, "R2 idle", stat_busy, 0);
                check(stat_wcomp == wcomp_m, "R5 completion flag", stat_wcomp, wcomp_m);
            end
            check(irq == ((ier_m[2] & !stat_busy) | (ier_m[1] & stat_wcomp) |
                          (ier_m[0] & stat_werr)), "R9 irq", irq, 0);
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        check(0, "R2 watchdog", 0, 1);
        finish_run();
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic status_read();
        @(posedge clk); #1 stat_rd = 1;
        @(posedge clk); #1 stat_rd = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy_m && n < 400) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    initial begin
        repeat (30) @(posedge clk);
        #1 rst_n = 1; started = 1;
        @(negedge clk);
        // R1 reset state
        check(stat_busy == 0, "R1 busy", stat_busy, 0);
        check(stat_wnext == 1, "R1 ready", stat_wnext, 1);
        check(stat_wcomp == 0, "R1 completion", stat_wcomp, 0);
        check(stat_werr == 0, "R1 error", stat_werr, 0);
        check(ier_o == 0, "R1 enables", ier_o, 0);
        check(irq == 0, "R1 irq", irq, 0);
        check(lp_wr == 0, "R1 strobe", lp_wr, 0);

        // R2 R3 R4: single write
        bus_write(8'h20, 32'hDEAD_BEEF);
        @(negedge clk);
        check(stat_busy == 1, "R2 busy after write", stat_busy, 1);
        wait_idle();
        check(stat_wcomp == 1, "R4 done flag", stat_wcomp, 1);
        status_read();
        @(negedge clk);
        check(stat_wcomp == 0, "R5 read clears", stat_wcomp, 0);

        // R6 overrun
        bus_write(8'h24, 32'h1234_5678);
        bus_write(8'h28, 32'hAAAA_5555);
        @(negedge clk);
        check(stat_werr == 1, "R6 overrun error", stat_werr, 1);
        wait_idle();
        check(exp_q.size() == 0, "R6 dropped write absent", exp_q.size(), 0);
        check(landed_cnt == 2, "R6 one strobe per accepted", landed_cnt, 2);

        // R7 clear only with bit 7
        bus_write(STAT, 32'hFFFF_FF7F);
        @(negedge clk);
        check(stat_werr == 1, "R7 bit7 clear ignored", stat_werr, 1);
        check(stat_busy == 0, "R7 no busy from status", stat_busy, 0);
        bus_write(STAT, 32'h0000_0080);
        @(negedge clk);
        check(stat_werr == 0, "R7 cleared", stat_werr, 0);
        status_read();

        // R9 error enable
        bus_write(IER, 32'h0000_0080);
        @(negedge clk);
        check(ier_o == 3'b001, "R8 error enable", ier_o, 3'b001);
        check(irq == 0, "R9 no irq", irq, 0);
        bus_write(8'h30, 32'h0000_0001);
        bus_write(8'h34, 32'h0000_0002);
        @(negedge clk);
        check(irq == 1, "R9 error irq", irq, 1);
        wait_idle();
        bus_write(STAT, 32'h0000_0080);
        status_read();
        @(negedge clk);
        check(irq == 0, "R9 irq cleared", irq, 0);

        // R8 enable write during crossing
        bus_write(8'h38, 32'hCAFE_F00D);
        bus_write(IER, 32'h0000_0100);
        @(negedge clk);
        check(stat_werr == 0, "R8 no error while busy", stat_werr, 0);
        check(ier_o == 3'b010, "R8 completion enable", ier_o, 3'b010);
        wait_idle();
        check(irq == 1, "R9 completion irq", irq, 1);
        status_read();
        @(negedge clk);
        check(irq == 0, "R9 completion irq cleared", irq, 0);

        // R9 ready enable
        bus_write(IER, 32'h0000_0200);
        @(negedge clk);
        check(irq == 1, "R9 ready irq", irq, 1);
        bus_write(8'h3C, 32'h0F0F_0F0F);
        @(negedge clk);
        check(irq == 0, "R9 ready irq drops when busy", irq, 0);
        wait_idle();
        status_read();
        bus_write(IER, 32'h0);

        // R3 varied patterns
        for (int i = 0; i < 6; i++) begin
            bus_write(8'h40 + 8'(i * 4), 32'h0101_0101 * (i + 1) ^ {i[7:0], 24'h0});
            wait_idle();
            status_read();
        end
        @(negedge clk);
        check(exp_q.size() == 0, "R3 all landed", exp_q.size(), 0);
        check(landed_cnt == accepted, "R3 strobe count", landed_cnt, accepted);
        finish_run();
    end
endmodule